// File: doc/BRIEF.md
# Register Rename Status Table

This block holds a small bank of floating-point registers. Each register has a producer tag beside it. The tag names the reservation station that will write the register next. A tag of zero means no write is pending. When an instruction issues, the block looks up two source registers. For each source it returns either the current value with a zero tag, or the tag of the station that will produce the value. The block then records the issuing station's tag against the destination register. A later writer always replaces an earlier pending tag, so name dependences are renamed away.

The block also watches the result broadcast bus. A broadcast carries the result data and the tag of the station that produced it. A register takes the data only while its own tag equals the broadcast tag. Once a newer writer has claimed a register, a result from an older writer cannot overwrite it. Source lookup is purely combinational, so a scheduler can sample it in the issue cycle. A broadcast in that same cycle is forwarded straight into the lookup result.

Top module: `rrst_table`

## Requirements
- R1: A register whose tag is zero has no pending writer. A lookup of that register returns its stored value with a zero tag.
- R2: A lookup is combinational from the source index. For a register with a nonzero tag, it returns that tag on the tag output. The value output carries meaning only when the tag output is zero.
- R3: When issue_valid is high, the destination's tag becomes issue_tag after the next clock edge. This holds even if an earlier writer is still pending. The issue_tag value must be nonzero.
- R4: A broadcast whose tag equals a register's nonzero tag writes the broadcast data into that register and clears its tag to zero at the next edge.
- R5: A broadcast whose tag differs from a register's tag leaves that register's value and tag unchanged. This includes a stale result from a writer that has been superseded. A broadcast tag of zero matches nothing.
- R6: A lookup in an issue cycle sees the tags from before that issue. An instruction whose source and destination are the same register gets the previous producer's tag, not its own.
- R7: If a valid broadcast tag equals a looked-up source's nonzero tag in the same cycle, the lookup returns the broadcast data with a zero tag.
- R8: Reset clears every tag and every stored value to zero.
- R9: If an issue and a matching broadcast target the same register in the same cycle, the register's tag becomes the new issue_tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_dst | input | IDX_W (3) | Destination register index |
| issue_tag | input | TAG_W (3) | Issuing station's tag, nonzero |
| src_a_idx | input | IDX_W (3) | First source register index |
| src_b_idx | input | IDX_W (3) | Second source register index |
| src_a_value | output | DATA_W (32) | First source value, meaningful when src_a_tag is zero |
| src_a_tag | output | TAG_W (3) | First source producer tag, zero when ready |
| src_b_value | output | DATA_W (32) | Second source value, meaningful when src_b_tag is zero |
| src_b_tag | output | TAG_W (3) | Second source producer tag, zero when ready |
| bcast_valid | input | 1 | A result is on the broadcast bus |
| bcast_tag | input | TAG_W (3) | Tag of the station producing the result |
| bcast_data | input | DATA_W (32) | Result data |

## Verification
Issue and result broadcast can happen in the same cycle, and they can touch the same register. A broadcast can complete the very producer that a source lookup is naming, which exercises the forwarding path. A broadcast can also complete the old producer of a register that the issue is claiming for a new writer. Directed steps create each collision on purpose. Random stimulus aims broadcast tags at tags that are currently pending, so these collisions also happen often during the random run. A bench model applies broadcast matching against the tags from before the cycle and then lets the issue override. It predicts each lookup in the cycle where the inputs are driven, and the bench compares the design's outputs with that prediction.

// File: rtl/rrst_pkg.sv
package rrst_pkg;
  // A station tag of zero means "no pending writer"; it never matches a broadcast.
  function automatic logic tag_hit(input logic [7:0] status, input logic bvalid,
                                   input logic [7:0] btag);
    return bvalid && (status != 8'd0) && (status == btag);
  endfunction
endpackage

// File: rtl/rrst_entry.sv
module rrst_entry #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic [TAG_W-1:0]  claim_tag,
  input  logic              bvalid,
  input  logic [TAG_W-1:0]  btag,
  input  logic [DATA_W-1:0] bdata,
  output logic [DATA_W-1:0] value,
  output logic [TAG_W-1:0]  status
);
  logic hit;
  assign hit = rrst_pkg::tag_hit(8'(status), bvalid, 8'(btag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value  <= '0;
      status <= '0;
    end else begin
      if (hit) value <= bdata;
      if (claim)    status <= claim_tag;
      else if (hit) status <= '0;
    end
  end

  p_claim_sets_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> status == $past(claim_tag));
  p_claim_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && hit) |=> status != '0);
  p_hit_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !claim) |=> (status == '0) && (value == $past(bdata)));
  p_miss_keeps_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(value));
  p_idle_keeps_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !claim) |=> $stable(status));
endmodule

// File: rtl/rrst_read_port.sv
module rrst_read_port #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  values,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   tags,
  input  logic                             bvalid,
  input  logic [TAG_W-1:0]                 btag,
  input  logic [DATA_W-1:0]                bdata,
  output logic [DATA_W-1:0]                out_value,
  output logic [TAG_W-1:0]                 out_tag
);
  logic [TAG_W-1:0] sel_tag;
  logic             bypass;

  assign sel_tag = tags[idx];
  assign bypass  = rrst_pkg::tag_hit(8'(sel_tag), bvalid, 8'(btag));

  always_comb begin
    if (bypass) begin
      out_value = bdata;
      out_tag   = '0;
    end else begin
      out_value = values[idx];
      out_tag   = sel_tag;
    end
  end

  p_bypass_forwards_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && out_tag != '0) |-> out_tag != btag);
  p_ready_passes_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tag == '0) |-> (out_value == values[idx]) && (out_tag == '0));
endmodule

// File: rtl/rrst_table.sv
module rrst_table #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [IDX_W-1:0]  issue_dst,
  input  logic [TAG_W-1:0]  issue_tag,
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  output logic [DATA_W-1:0] src_a_value,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic [DATA_W-1:0] src_b_value,
  output logic [TAG_W-1:0]  src_b_tag,
  input  logic              bcast_valid,
  input  logic [TAG_W-1:0]  bcast_tag,
  input  logic [DATA_W-1:0] bcast_data
);
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_value;
  logic [NUM_REGS-1:0][TAG_W-1:0]  reg_tag;
  logic [NUM_REGS-1:0]             claim_vec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    assign claim_vec[g] = issue_valid && (issue_dst == IDX_W'(g));
    rrst_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .claim(claim_vec[g]), .claim_tag(issue_tag),
      .bvalid(bcast_valid), .btag(bcast_tag), .bdata(bcast_data),
      .value(reg_value[g]), .status(reg_tag[g])
    );
  end

  rrst_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_port_a (
    .clk(clk), .rst_n(rst_n), .idx(src_a_idx),
    .values(reg_value), .tags(reg_tag),
    .bvalid(bcast_valid), .btag(bcast_tag), .bdata(bcast_data),
    .out_value(src_a_value), .out_tag(src_a_tag)
  );

  rrst_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_port_b (
    .clk(clk), .rst_n(rst_n), .idx(src_b_idx),
    .values(reg_value), .tags(reg_tag),
    .bvalid(bcast_valid), .btag(bcast_tag), .bdata(bcast_data),
    .out_value(src_b_value), .out_tag(src_b_tag)
  );

  p_issue_tag_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> issue_tag != '0);
  p_one_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));
  p_reset_clears_r8: assert property (@(posedge clk)
    !rst_n |=> (reg_tag == '0) && (reg_value == '0));
endmodule

// File: tb/tb_rrst_table.sv
module tb_rrst_table;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int DW = 32;
  localparam int TW = 3;
  localparam int IW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic issue_valid = 0;
  logic [IW-1:0] issue_dst = 0;
  logic [TW-1:0] issue_tag = 1;
  logic [IW-1:0] src_a_idx = 0, src_b_idx = 0;
  logic [DW-1:0] src_a_value, src_b_value;
  logic [TW-1:0] src_a_tag, src_b_tag;
  logic bcast_valid = 0;
  logic [TW-1:0] bcast_tag = 0;
  logic [DW-1:0] bcast_data = 0;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [DW-1:0] mval [NREG];
  logic [TW-1:0] mtag [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  rrst_table dut (.*);

  function automatic logic [TW-1:0] exp_tag(input int r);
    if (mtag[r] != 0 && bcast_valid && bcast_tag == mtag[r]) return '0;
    return mtag[r];
  endfunction

  function automatic logic [DW-1:0] exp_val(input int r);
    if (mtag[r] != 0 && bcast_valid && bcast_tag == mtag[r]) return bcast_data;
    return mval[r];
  endfunction

  task automatic check(input string req, input string what, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_src(input string req, input int r, input logic [DW-1:0] v,
                           input logic [TW-1:0] t);
    check(req, "tag", DW'(t), DW'(exp_tag(r)));
    if (exp_tag(r) == 0) check(req, "value", v, exp_val(r));
  endtask

  task automatic step(input logic iv, input int dst, input int itag, input int sa,
                      input int sb, input logic bv, input int bt, input logic [DW-1:0] bd,
                      input string req);
    logic [TW-1:0] pre [NREG];
    @(negedge clk);
    issue_valid = iv; issue_dst = IW'(dst); issue_tag = TW'(itag);
    src_a_idx = IW'(sa); src_b_idx = IW'(sb);
    bcast_valid = bv; bcast_tag = TW'(bt); bcast_data = bd;
    #1;
    check_src(req, sa, src_a_value, src_a_tag);
    check_src(req, sb, src_b_value, src_b_tag);
    @(posedge clk);
    for (int r = 0; r < NREG; r++) pre[r] = mtag[r];
    for (int r = 0; r < NREG; r++)
      if (bv && pre[r] != 0 && pre[r] == TW'(bt)) begin
        mval[r] = bd; mtag[r] = '0;
      end
    if (iv) mtag[dst] = TW'(itag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7319);
    for (int r = 0; r < NREG; r++) begin mval[r] = '0; mtag[r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R8: reset state, every register idle with zero value
    for (int r = 0; r < NREG; r += 2) step(0, 0, 1, r, r + 1, 0, 0, 0, "R8");
    // R1 then R3: claim r2
    step(1, 2, 1, 2, 5, 0, 0, 0, "R1");
    // R6: same-register source and destination sees old producer
    step(1, 2, 2, 2, 2, 0, 0, 0, "R6");
    // R5: stale result from superseded writer
    step(0, 0, 1, 2, 2, 1, 1, 32'hAAAA_0001, "R5");
    step(0, 0, 1, 2, 3, 0, 0, 0, "R5");
    // R5: zero broadcast tag matches nothing
    step(0, 0, 1, 2, 0, 1, 0, 32'hDEAD_0000, "R5");
    // R7: same-cycle forwarding
    step(0, 0, 1, 2, 2, 1, 2, 32'h5555_1234, "R7");
    // R4: value stored, tag cleared
    step(0, 0, 1, 2, 0, 0, 0, 0, "R4");
    // R9: issue and matching broadcast on one register
    step(1, 3, 4, 3, 3, 0, 0, 0, "R3");
    step(1, 3, 5, 3, 3, 1, 4, 32'h0BAD_BEEF, "R9");
    step(0, 0, 1, 3, 3, 0, 0, 0, "R9");
    step(0, 0, 1, 3, 2, 1, 5, 32'h1357_9BDF, "R7");
    step(0, 0, 1, 3, 2, 0, 0, 0, "R4");
    // R2/R3 random traffic, broadcasts aimed at pending tags
    for (int n = 0; n < 3000; n++) begin
      int bt;
      bt = ($urandom % 4 != 0) ? int'(mtag[$urandom % NREG]) : int'($urandom % 8);
      step($urandom % 2 == 0, $urandom % NREG, 1 + ($urandom % 7), $urandom % NREG,
           $urandom % NREG, $urandom % 2 == 0, bt, $urandom, "R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule